// File: doc/BRIEF.md
# Microwire EEPROM access controller

This block runs one serial EEPROM operation at a time over a four-wire Microwire-style link. The wires are chip select, serial clock, data to the ROM and data from the ROM. Software uses a small register port for the rest. It loads a 2-bit opcode and a byte address into the command register. For data-carrying commands it also loads a byte into the data register. It then sets the start bit in the control register and reads that register until the start bit drops back to zero. After a read, the byte returned by the ROM is in the data register.

Some commands run on a timer inside the ROM: write, write-all, erase and erase-all. Starting one of them raises a sticky poll-pending flag. While that flag is set, a start request does not launch a command. It runs a ready check instead: chip select goes high, the line to the ROM is held low, and the level the ROM returns is sampled once. The flag clears only when the ROM reports ready.

A divider register sets the serial clock rate. Its value is the length of each clock phase, counted in system clock cycles.

Top module: `mwire_rom_ctrl`

## Requirements
- R1: After reset, the control register (register 2) reads 0, the divider register (register 3) reads DIV_RST, and rom_cs, rom_sk and rom_di are low.
- R2: A command frame is sent MSB first and has these fields in order:
  - a 1 bit;
  - the opcode, taken from bits ADDR_W+1:ADDR_W of the command register (register 0);
  - the ADDR_W address bits, taken from bits ADDR_W-1:0 of the command register.
- R3: Opcodes are 10 read, 01 write and 11 erase.
  - Opcode 00 picks one of four commands by address bits ADDR_W-1:ADDR_W-2: 01 write-all, 10 erase-all, 11 write-enable, 00 write-disable.
  - Write and write-all frames add the 8 bits of the data register (register 1). Erase, erase-all, write-enable and write-disable frames end after the address.
- R4: A write to the control register starts an access only when it has bit 0 = 1 and bit 1 = 0 in the same write. Bit 0 then reads 1 until the access ends and drops to 0 by itself.
- R5: A read frame adds 8 clock periods after the address, with rom_di held low. The 8 bits sampled from rom_do in those periods, MSB first, are stored in the data register.
- R6: Starting write, write-all, erase or erase-all sets poll-pending (control bit 2). The flag stays set after the frame ends.
- R7: Write-enable and write-disable never set poll-pending.
- R8: A start while poll-pending is set sends a one-period ready-check frame with rom_di low.
  - If rom_do is high at its rising clock edge, poll-pending clears.
  - If rom_do is low, poll-pending stays set.
- R9: A start while poll-pending is clear launches the command held in the command register.
- R10: rom_di changes only while rom_sk is low. It is shifted at falling edges and stays stable while rom_sk is high.
- R11: rom_sk stays low while rom_cs is low. Between frames, rom_cs stays low for at least two divider phases (one serial period).
- R12: Start writes made while an access is running are ignored and produce no extra frame.
- R13: Each high and low phase of rom_sk lasts the number of system clock cycles held in the divider register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 command, 1 data, 2 control, 3 divider |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register selected by reg_addr, one cycle later |
| rom_cs | output | 1 | Chip select to the EEPROM |
| rom_sk | output | 1 | Serial clock to the EEPROM |
| rom_di | output | 1 | Serial data to the EEPROM |
| rom_do | input | 1 | Serial data from the EEPROM |

## Verification
A corrupted frame register or bit counter shows up in the very frame it affects: the next falling edge of chip select closes a frame with the wrong length or the wrong bits. A wrong poll-pending flag shows up at the next start. That start then sends a full command where a one-bit ready check was due, or the reverse, and the control register read straight after the access shows the mismatch. A divider or gap counter that is off changes the measured clock phase width or the chip-select idle time within the same frame.

// File: rtl/mwr_pkg.sv
package mwr_pkg;
  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_SHIFT = 2'd1,
    ENG_GAP   = 2'd2
  } eng_state_t;

  // register select codes
  localparam logic [1:0] RA_CMD  = 2'd0;
  localparam logic [1:0] RA_DATA = 2'd1;
  localparam logic [1:0] RA_CTRL = 2'd2;
  localparam logic [1:0] RA_DIV  = 2'd3;

  // opcode field values
  localparam logic [1:0] OP_EXT   = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_ERASE = 2'b11;

  // sub-command in the two top address bits when opcode is OP_EXT
  localparam logic [1:0] EXT_WDS   = 2'b00;
  localparam logic [1:0] EXT_WRALL = 2'b01;
  localparam logic [1:0] EXT_ERALL = 2'b10;
  localparam logic [1:0] EXT_WEN   = 2'b11;

  // control register bit positions
  localparam int CTRL_START = 0;
  localparam int CTRL_PAR   = 1;
  localparam int CTRL_PEND  = 2;
endpackage

// File: rtl/mwr_clkdiv.sv
module mwr_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] half,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W:0]   nxt;

  assign nxt = {1'b0, cnt} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (nxt >= {1'b0, half}) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= nxt[DIV_W-1:0];
      tick <= 1'b0;
    end
  end

  // R13: with a phase longer than one cycle, ticks never come back to back
  assert_tick_spacing_R13: assert property (@(posedge clk) disable iff (rst)
    (tick && half > 1) |=> !tick);
endmodule

// File: rtl/mwr_cmd_decode.sv
module mwr_cmd_decode
  import mwr_pkg::*;
#(
  parameter int ADDR_W  = 7,
  parameter int FRAME_W = ADDR_W + 11,
  parameter int LEN_W   = $clog2(FRAME_W + 1)
) (
  input  logic [1:0]         op,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [7:0]         wdata,
  input  logic               poll,
  output logic [FRAME_W-1:0] frame,
  output logic [LEN_W-1:0]   len,
  output logic               slow
);
  localparam int HDR_W = ADDR_W + 3;

  logic [1:0] ext;
  logic       carries_data;
  logic       long_frame;

  always_comb begin
    ext          = addr[ADDR_W-1 -: 2];
    carries_data = 1'b0;
    long_frame   = 1'b0;
    slow         = 1'b0;
    case (op)
      OP_READ:  long_frame = 1'b1;
      OP_WRITE: begin carries_data = 1'b1; long_frame = 1'b1; slow = 1'b1; end
      OP_ERASE: slow = 1'b1;
      default: begin
        case (ext)
          EXT_WRALL: begin carries_data = 1'b1; long_frame = 1'b1; slow = 1'b1; end
          EXT_ERALL: slow = 1'b1;
          EXT_WEN:   slow = 1'b0;
          EXT_WDS:   slow = 1'b0;
          default:   slow = 1'b0;
        endcase
      end
    endcase
    frame = {1'b1, op, addr, (carries_data ? wdata : 8'h00)};
    len   = long_frame ? LEN_W'(FRAME_W) : LEN_W'(HDR_W);
    if (poll) begin
      frame = '0;
      len   = LEN_W'(1);
      slow  = 1'b0;
    end
  end
endmodule

// File: rtl/mwr_frame_eng.sv
module mwr_frame_eng
  import mwr_pkg::*;
#(
  parameter int FRAME_W = 18,
  parameter int LEN_W   = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               go,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic [LEN_W-1:0]   len_in,
  input  logic               poll_in,
  input  logic               tick,
  input  logic               do_in,
  output logic               busy,
  output logic               done,
  output logic [7:0]         rx_byte,
  output logic               cs,
  output logic               sk,
  output logic               di
);
  eng_state_t         state;
  logic [FRAME_W-1:0] shreg;
  logic [LEN_W-1:0]   bits_left;
  logic               gap_cnt;
  logic               poll_q;

  assign busy = (state != ENG_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ENG_IDLE;
      cs        <= 1'b0;
      sk        <= 1'b0;
      di        <= 1'b0;
      shreg     <= '0;
      bits_left <= '0;
      gap_cnt   <= 1'b0;
      poll_q    <= 1'b0;
      rx_byte   <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ENG_IDLE: if (go) begin
          state     <= ENG_SHIFT;
          cs        <= 1'b1;
          sk        <= 1'b0;
          di        <= frame_in[FRAME_W-1];
          shreg     <= frame_in << 1;
          bits_left <= len_in;
          poll_q    <= poll_in;
        end
        ENG_SHIFT: if (tick) begin
          if (!sk) begin
            sk      <= 1'b1;
            rx_byte <= {rx_byte[6:0], do_in};
          end else begin
            sk <= 1'b0;
            if (bits_left == LEN_W'(1)) begin
              cs      <= 1'b0;
              di      <= 1'b0;
              gap_cnt <= 1'b0;
              state   <= ENG_GAP;
            end else begin
              di        <= shreg[FRAME_W-1];
              shreg     <= shreg << 1;
              bits_left <= bits_left - 1'b1;
            end
          end
        end
        ENG_GAP: if (tick) begin
          if (gap_cnt) begin
            state <= ENG_IDLE;
            done  <= 1'b1;
          end else begin
            gap_cnt <= 1'b1;
          end
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

  // R10: data to the ROM holds while the serial clock is high
  assert_di_stable_R10: assert property (@(posedge clk) disable iff (rst)
    sk |-> $stable(di));
  // R11: no serial clock pulse outside a frame
  assert_sk_in_frame_R11: assert property (@(posedge clk) disable iff (rst)
    !cs |-> !sk);
  // R8: a ready check keeps the line to the ROM low
  assert_poll_di_low_R8: assert property (@(posedge clk) disable iff (rst)
    (cs && poll_q) |-> !di);
  // R12: a launch is only taken by an idle engine
  assert_go_when_idle_R12: assert property (@(posedge clk) disable iff (rst)
    go |-> (state == ENG_IDLE));
endmodule

// File: rtl/mwire_rom_ctrl.sv
module mwire_rom_ctrl
  import mwr_pkg::*;
#(
  parameter int ADDR_W  = 7,
  parameter int DIV_W   = 8,
  parameter int DIV_RST = 4,
  parameter int REG_W   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             rom_cs,
  output logic             rom_sk,
  output logic             rom_di,
  input  logic             rom_do
);
  localparam int FRAME_W = ADDR_W + 11;
  localparam int LEN_W   = $clog2(FRAME_W + 1);

  logic [ADDR_W-1:0]  cmd_addr;
  logic [1:0]         cmd_op;
  logic [7:0]         data_q;
  logic [DIV_W-1:0]   half_q;
  logic               start_q;
  logic               poll_pend;
  logic               cur_poll;
  logic               cur_read;

  logic [FRAME_W-1:0] dec_frame;
  logic [LEN_W-1:0]   dec_len;
  logic               dec_slow;
  logic               go;
  logic               tick;
  logic               eng_busy;
  logic               eng_done;
  logic [7:0]         eng_rx;

  assign go = reg_wr && (reg_addr == RA_CTRL) && reg_wdata[CTRL_START]
              && !reg_wdata[CTRL_PAR] && !start_q;

  mwr_cmd_decode #(.ADDR_W(ADDR_W), .FRAME_W(FRAME_W), .LEN_W(LEN_W)) u_dec (
    .op(cmd_op), .addr(cmd_addr), .wdata(data_q), .poll(poll_pend),
    .frame(dec_frame), .len(dec_len), .slow(dec_slow)
  );

  mwr_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .en(eng_busy), .half(half_q), .tick(tick)
  );

  mwr_frame_eng #(.FRAME_W(FRAME_W), .LEN_W(LEN_W)) u_eng (
    .clk(clk), .rst(rst), .go(go), .frame_in(dec_frame), .len_in(dec_len),
    .poll_in(poll_pend), .tick(tick), .do_in(rom_do), .busy(eng_busy),
    .done(eng_done), .rx_byte(eng_rx), .cs(rom_cs), .sk(rom_sk), .di(rom_di)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_addr  <= '0;
      cmd_op    <= '0;
      data_q    <= '0;
      half_q    <= DIV_W'(DIV_RST);
      start_q   <= 1'b0;
      poll_pend <= 1'b0;
      cur_poll  <= 1'b0;
      cur_read  <= 1'b0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          RA_CMD:  {cmd_op, cmd_addr} <= reg_wdata[ADDR_W+1:0];
          RA_DATA: data_q <= reg_wdata[7:0];
          RA_DIV:  half_q <= reg_wdata[DIV_W-1:0];
          default: ;
        endcase
      end
      if (go) begin
        start_q  <= 1'b1;
        cur_poll <= poll_pend;
        cur_read <= !poll_pend && (cmd_op == OP_READ);
        if (!poll_pend && dec_slow) poll_pend <= 1'b1;
      end
      if (eng_done) begin
        start_q <= 1'b0;
        if (cur_poll && eng_rx[0]) poll_pend <= 1'b0;
        if (cur_read) data_q <= eng_rx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      reg_rdata <= '0;
      case (reg_addr)
        RA_CMD:  reg_rdata <= REG_W'({cmd_op, cmd_addr});
        RA_DATA: reg_rdata <= REG_W'(data_q);
        RA_CTRL: begin
          reg_rdata[CTRL_START] <= start_q;
          reg_rdata[CTRL_PEND]  <= poll_pend;
        end
        default: reg_rdata <= REG_W'(half_q);
      endcase
    end
  end

  // R4: the start bit only drops when the engine reports the end of an access
  assert_start_clear_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(start_q) |-> $past(eng_done));
  // R6 and R7: poll-pending rises only together with a frame being opened
  assert_pend_rise_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(poll_pend) |-> rom_cs);
  // R8: poll-pending drops only at the end of an access
  assert_pend_fall_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(poll_pend) |-> $past(eng_done));
  // R12: a frame on the wires always has the start bit showing busy
  assert_cs_busy_R12: assert property (@(posedge clk) disable iff (rst)
    rom_cs |-> start_q);
endmodule

// File: tb/mwire_rom_ctrl_test.sv
`timescale 1ns/1ps
module mwire_rom_ctrl_test;
  localparam int AW = 7;
  localparam int DIVR = 4;
  localparam int LONG = AW + 11;
  localparam int SHORT = AW + 3;

  typedef struct {
    int          len;
    logic [31:0] bits;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic rom_cs, rom_sk, rom_di;
  logic rom_do_r = 1'b0;

  mwire_rom_ctrl #(.ADDR_W(AW), .DIV_W(8), .DIV_RST(DIVR), .REG_W(16)) uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rom_cs(rom_cs),
    .rom_sk(rom_sk), .rom_di(rom_di), .rom_do(rom_do_r)
  );

  always #2 clk = ~clk;

  int n_checks = 0;
  int n_err = 0;
  exp_t exp_q[$];
  int frames = 0;
  int cur_div = DIVR;
  int last_hi = 0;
  int gap_viol = 0;
  int di_viol = 0;
  bit rom_busy = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  function automatic logic [7:0] rom_byte(input logic [AW-1:0] a);
    return 8'((a * 37) ^ 8'h5A);
  endfunction

  // ROM model and frame monitor
  int fcnt = 0;
  logic [31:0] fbits = '0;
  bit rd_active = 1'b0;
  logic [7:0] rd_val = '0;
  longint t_fall = 0;
  bit have_fall = 1'b0;
  longint t_rise = 0;

  always @(posedge rom_cs) begin
    fcnt = 0;
    fbits = '0;
    rd_active = 1'b0;
    rom_do_r = !rom_busy;
    if (have_fall && (($time - t_fall) < 2 * cur_div * 4)) gap_viol++;
  end

  always @(posedge rom_sk) begin
    t_rise = $time;
    if (rom_cs) begin
      fbits = {fbits[30:0], rom_di};
      fcnt++;
      if (fcnt == SHORT && fbits[AW+2:AW] == 3'b110) begin
        rd_active = 1'b1;
        rd_val = rom_byte(fbits[AW-1:0]);
      end
      if (rd_active && fcnt >= SHORT && fcnt < SHORT + 8)
        rom_do_r = rd_val[7 - (fcnt - SHORT)];
    end
  end

  always @(negedge rom_sk) last_hi = int'(($time - t_rise) / 4);

  always @(negedge rom_cs) begin
    exp_t e;
    t_fall = $time;
    have_fall = 1'b1;
    rom_do_r = 1'b0;
    frames++;
    if (exp_q.size() == 0) begin
      check(1'b0, "R12 unexpected frame", fbits, 32'h0);
    end else begin
      e = exp_q.pop_front();
      check(fcnt == e.len, {e.tag, " frame length"}, fcnt, e.len);
      check(fbits == e.bits, {e.tag, " frame bits"}, fbits, e.bits);
    end
  end

  logic prev_di = 1'b0;
  always @(negedge clk) begin
    if (!rst && rom_sk && rom_di !== prev_di) di_viol++;
    prev_di = rom_di;
  end

  task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] v;
    for (int i = 0; i < 5000; i++) begin
      reg_read(2'd2, v);
      if (!v[0]) break;
    end
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic [AW-1:0] a, input logic [7:0] d,
                         input int kind, input string tag);
    exp_t e;
    reg_write(2'd1, {8'h00, d});
    reg_write(2'd0, 16'({op, a}));
    e.tag = tag;
    if (kind == 0) begin e.len = SHORT; e.bits = 32'({1'b1, op, a}); end
    else if (kind == 1) begin e.len = LONG; e.bits = 32'({1'b1, op, a, d}); end
    else begin e.len = LONG; e.bits = 32'({1'b1, op, a, 8'h00}); end
    exp_q.push_back(e);
    reg_write(2'd2, 16'h0001);
    wait_idle();
  endtask

  task automatic run_poll(input string tag);
    exp_t e;
    e.len = 1; e.bits = 32'h0; e.tag = tag;
    exp_q.push_back(e);
    reg_write(2'd2, 16'h0001);
    wait_idle();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL R4 watchdog: actual running expected idle");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    int f0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    check(rom_cs == 0 && rom_sk == 0 && rom_di == 0, "R1 pins", {rom_cs, rom_sk, rom_di}, 0);
    reg_read(2'd2, v); check(v == 0, "R1 control", v, 0);
    reg_read(2'd3, v); check(v == DIVR, "R1 divider", v, DIVR);

    reg_write(2'd3, 16'd3); cur_div = 3;

    // R7 write-enable: short frame, no poll
    run_cmd(2'b00, 7'h60, 8'h00, 0, "R3 R7 write-enable");
    reg_read(2'd2, v); check(v == 0, "R7 enable leaves pending clear", v, 0);
    check(last_hi == 3, "R13 phase width 3", last_hi, 3);

    // R6 write: long frame with data, pending set
    run_cmd(2'b01, 7'h15, 8'hC3, 1, "R2 R3 write");
    rom_busy = 1'b1;
    reg_read(2'd2, v); check(v == 16'h4, "R4 R6 write sets pending", v, 16'h4);

    // R8 poll while ROM busy
    run_poll("R8 poll busy");
    reg_read(2'd2, v); check(v == 16'h4, "R8 busy keeps pending", v, 16'h4);
    rom_busy = 1'b0;
    run_poll("R8 poll ready");
    reg_read(2'd2, v); check(v == 0, "R8 ready clears pending", v, 0);

    // R9 R5 read after pending cleared
    run_cmd(2'b10, 7'h2A, 8'h00, 2, "R5 R9 read");
    reg_read(2'd1, v); check(v == rom_byte(7'h2A), "R5 read data", v, rom_byte(7'h2A));
    reg_read(2'd2, v); check(v == 0, "R5 read leaves pending clear", v, 0);

    // erase, then poll ready
    run_cmd(2'b11, 7'h07, 8'h99, 0, "R3 erase");
    reg_read(2'd2, v); check(v == 16'h4, "R6 erase sets pending", v, 16'h4);
    run_poll("R8 poll after erase");

    // write-all with data
    run_cmd(2'b00, 7'h25, 8'h5E, 1, "R3 write-all");
    reg_read(2'd2, v); check(v == 16'h4, "R6 write-all sets pending", v, 16'h4);
    run_poll("R8 poll after write-all");

    // erase-all
    run_cmd(2'b00, 7'h41, 8'hFF, 0, "R3 erase-all");
    reg_read(2'd2, v); check(v == 16'h4, "R6 erase-all sets pending", v, 16'h4);
    run_poll("R8 poll after erase-all");

    // write-disable
    run_cmd(2'b00, 7'h1F, 8'h00, 0, "R3 R7 write-disable");
    reg_read(2'd2, v); check(v == 0, "R7 disable leaves pending clear", v, 0);

    // R4 start with parallel-start bit set is ignored
    f0 = frames;
    reg_write(2'd2, 16'h0003);
    repeat (40) @(negedge clk);
    reg_read(2'd2, v); check(v == 0, "R4 par bit blocks start", v, 0);
    check(frames == f0 && rom_cs == 0, "R4 no frame", frames - f0, 0);

    // R12 start while busy is ignored
    f0 = frames;
    reg_write(2'd1, 16'h0000);
    reg_write(2'd0, 16'({2'b10, 7'h33}));
    begin
      exp_t e;
      e.len = LONG; e.bits = 32'({1'b1, 2'b10, 7'h33, 8'h00}); e.tag = "R12 read";
      exp_q.push_back(e);
    end
    reg_write(2'd2, 16'h0001);
    reg_write(2'd2, 16'h0001);
    reg_write(2'd2, 16'h0001);
    wait_idle();
    repeat (60) @(negedge clk);
    check(frames - f0 == 1, "R12 one frame only", frames - f0, 1);
    check(exp_q.size() == 0, "R12 queue drained", exp_q.size(), 0);
    reg_read(2'd1, v); check(v == rom_byte(7'h33), "R5 second read", v, rom_byte(7'h33));

    // R13 other divider settings
    reg_write(2'd3, 16'd1); cur_div = 1;
    run_cmd(2'b00, 7'h70, 8'h00, 0, "R13 enable fast");
    check(last_hi == 1, "R13 phase width 1", last_hi, 1);
    reg_write(2'd3, 16'd6); cur_div = 6;
    run_cmd(2'b00, 7'h00, 8'h00, 0, "R13 disable slow");
    check(last_hi == 6, "R13 phase width 6", last_hi, 6);

    check(gap_viol == 0, "R11 chip select gap", gap_viol, 0);
    check(di_viol == 0, "R10 data stable while clock high", di_viol, 0);
    check(exp_q.size() == 0, "R2 all frames seen", exp_q.size(), 0);
    finish_run();
  end
endmodule